// File: doc/BRIEF.md
# Multiply/Divide Result Register Hazard Checker

This block observes retired instructions that read or write the two multiply/divide result registers, called HI and LO here. It also observes the multiply and divide operations that write both registers at once. Each cycle it may accept one event. An event carries an instruction address, a cycle timestamp and a mode flag. For each register the block keeps the time and address of the most recent write, the most recent read and the most recent operation.

From that history it checks three ordering rules:

- **Write spacing.** A write must not come too soon after a read of the same register.
- **Operation spacing.** A multiply or divide must not come too soon after a read of either register.
- **Cross-register corruption.** A read is corrupted when, since the last operation, only the other register has been written.

A violation produces a registered one-cycle report. The report holds a rule code, the current address and the conflicting earlier address or addresses. It is meant for simulation monitors or debug logic placed beside a pipeline.

Top module: `hilo_hazard_chk`

## Requirements
- R1: After reset the outputs are zero. Every history entry is invalid, so the first events of any kind raise no violation.
- R2: With `relaxed`=0, a write to HI (kind 0) or LO (kind 1) is flagged when that register's last read time + 3 > the current time. Gaps of 0, 1 and 2 cycles are flagged and a gap of 3 is not. The report uses code 1 and `conf_pc_a` = the read's address.
- R3: The write-spacing rule looks only at reads of the same register. A read of LO followed at once by a write of HI is not flagged.
- R4: A multiply (kind 4) or divide (kind 5) is flagged with code 2 when either register's last read is closer than 3 cycles. HI is tested first, and `conf_pc_a` = the address of the read that failed first.
- R5: With `relaxed`=1, the spacing test is skipped for writes and multiplies. Divides are still tested.
- R6: A read of HI (kind 2) or LO (kind 3) is flagged with code 3 in either mode when three conditions all hold. The other register was written after the last operation. This register's last write, if valid, came before that operation. No read falls in the exemption window. The report gives `conf_pc_a` = the operation address and `conf_pc_b` = the other register's write address.
- R7: A read of the same register that lies strictly between the operation and the other register's write exempts the corruption rule. A read at exactly the operation's time does not exempt it.
- R8: A read of the other register that lies in the same window also exempts the corruption rule.
- R9: No corruption is flagged when this register was itself written after the last operation.
- R10: History is updated on every event, whether or not the event was flagged and in either mode. A multiply or divide records its time and address as the operation for both registers.
- R11: `viol` is high for exactly the cycle after an offending event. When `viol` is low, `viol_code`, `viol_pc`, `conf_pc_a` and `conf_pc_b` are 0. Kinds 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 3 | Event kind: 0 write HI, 1 write LO, 2 read HI, 3 read LO, 4 multiply, 5 divide |
| ev_pc | input | 32 | Address of the instruction |
| ev_time | input | 32 | Cycle timestamp of the event |
| relaxed | input | 1 | 1 skips the spacing test for writes and multiplies |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 2 | 1 write spacing, 2 operation spacing, 3 corruption |
| viol_pc | output | 32 | Address of the offending instruction |
| conf_pc_a | output | 32 | Earlier read address, or the operation address for a corruption |
| conf_pc_b | output | 32 | Other register's write address for a corruption, else 0 |

## Verification
Two things can fall in the same cycle: a multiply or divide failing the spacing test against both HI and LO. The bench provokes this by reading HI and then LO in the two cycles just before a divide. It then expects the report to name the HI read, which shows the fixed HI-first order. A second overlap is a flagged event whose history update still takes effect. The bench judges this with a later corruption or spacing report that can only contain the flagged event's address.

// File: rtl/hilo_chk_pkg.sv
package hilo_chk_pkg;

    localparam int ADDR_W = 32;
    localparam int TIME_W = 32;

    typedef enum logic [2:0] {
        EV_WR_HI = 3'd0,
        EV_WR_LO = 3'd1,
        EV_RD_HI = 3'd2,
        EV_RD_LO = 3'd3,
        EV_MUL   = 3'd4,
        EV_DIV   = 3'd5
    } ev_kind_e;

    typedef enum logic [1:0] {
        VC_NONE    = 2'd0,
        VC_WR_GAP  = 2'd1,
        VC_OP_GAP  = 2'd2,
        VC_CORRUPT = 2'd3
    } viol_e;

    typedef struct packed {
        logic              vld;
        logic [TIME_W-1:0] t;
        logic [ADDR_W-1:0] pc;
    } stamp_t;

    typedef struct packed {
        stamp_t wr;
        stamp_t rd;
        stamp_t op;
    } hist_t;

    // A valid read stamp that is closer than 'gap' cycles to 'now'
    function automatic logic too_close(stamp_t rd, logic [TIME_W-1:0] now,
                                       logic [TIME_W-1:0] gap);
        logic [TIME_W:0] lim;
        lim = {1'b0, rd.t} + {1'b0, gap};
        return rd.vld && (lim > {1'b0, now});
    endfunction

    // A valid stamp strictly inside the open interval (lo, hi)
    function automatic logic inside_win(stamp_t s, logic [TIME_W-1:0] lo,
                                        logic [TIME_W-1:0] hi);
        return s.vld && (s.t > lo) && (s.t < hi);
    endfunction

    // Corruption test for a read of 'own' while 'peer' is the other register
    function automatic logic corrupted(hist_t own, hist_t peer);
        logic peer_wr_after, own_wr_before;
        peer_wr_after = own.op.vld && peer.wr.vld && (peer.wr.t > own.op.t);
        own_wr_before = !own.wr.vld || (own.wr.t < own.op.t);
        return peer_wr_after && own_wr_before
            && !inside_win(own.rd,  own.op.t, peer.wr.t)
            && !inside_win(peer.rd, own.op.t, peer.wr.t);
    endfunction

endpackage

// File: rtl/hilo_hist.sv
module hilo_hist
    import hilo_chk_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  ev_kind_e          ev_kind,
    input  logic [ADDR_W-1:0] ev_pc,
    input  logic [TIME_W-1:0] ev_time,
    output hist_t             hist
);

    localparam ev_kind_e WR_K = (IDX != 0) ? EV_WR_LO : EV_WR_HI;
    localparam ev_kind_e RD_K = (IDX != 0) ? EV_RD_LO : EV_RD_HI;

    stamp_t now_stamp;
    assign now_stamp = '{vld: 1'b1, t: ev_time, pc: ev_pc};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (ev_valid) begin
            if (ev_kind == WR_K)
                hist.wr <= now_stamp;
            if (ev_kind == RD_K)
                hist.rd <= now_stamp;
            if (ev_kind == EV_MUL || ev_kind == EV_DIV)
                hist.op <= now_stamp;
        end
    end

    a_r10_read_recorded: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == RD_K) |=> (hist.rd.vld && hist.rd.pc == $past(ev_pc)));

    a_r10_op_recorded: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && (ev_kind == EV_MUL || ev_kind == EV_DIV))
            |=> (hist.op.vld && hist.op.t == $past(ev_time)));

    a_r10_write_recorded: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == WR_K) |=> (hist.wr.vld && hist.wr.pc == $past(ev_pc)));

endmodule

// File: rtl/hilo_rules.sv
module hilo_rules
    import hilo_chk_pkg::*;
#(
    parameter int MIN_GAP = 3
) (
    input  logic              ev_valid,
    input  ev_kind_e          ev_kind,
    input  logic [TIME_W-1:0] ev_time,
    input  logic              relaxed,
    input  hist_t             h_hi,
    input  hist_t             h_lo,
    output viol_e             code,
    output logic [ADDR_W-1:0] pc_a,
    output logic [ADDR_W-1:0] pc_b
);

    localparam logic [TIME_W-1:0] GAP = TIME_W'(MIN_GAP);

    logic close_hi, close_lo;
    assign close_hi = too_close(h_hi.rd, ev_time, GAP);
    assign close_lo = too_close(h_lo.rd, ev_time, GAP);

    always_comb begin
        code = VC_NONE;
        pc_a = '0;
        pc_b = '0;
        if (ev_valid) begin
            case (ev_kind)
                EV_WR_HI: if (!relaxed && close_hi) begin
                    code = VC_WR_GAP;
                    pc_a = h_hi.rd.pc;
                end
                EV_WR_LO: if (!relaxed && close_lo) begin
                    code = VC_WR_GAP;
                    pc_a = h_lo.rd.pc;
                end
                EV_MUL, EV_DIV: if (ev_kind == EV_DIV || !relaxed) begin
                    if (close_hi) begin
                        code = VC_OP_GAP;
                        pc_a = h_hi.rd.pc;
                    end else if (close_lo) begin
                        code = VC_OP_GAP;
                        pc_a = h_lo.rd.pc;
                    end
                end
                EV_RD_HI: if (corrupted(h_hi, h_lo)) begin
                    code = VC_CORRUPT;
                    pc_a = h_hi.op.pc;
                    pc_b = h_lo.wr.pc;
                end
                EV_RD_LO: if (corrupted(h_lo, h_hi)) begin
                    code = VC_CORRUPT;
                    pc_a = h_lo.op.pc;
                    pc_b = h_hi.wr.pc;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/hilo_hazard_chk.sv
module hilo_hazard_chk
    import hilo_chk_pkg::*;
#(
    parameter int MIN_GAP = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [2:0]        ev_kind,
    input  logic [ADDR_W-1:0] ev_pc,
    input  logic [TIME_W-1:0] ev_time,
    input  logic              relaxed,
    output logic              viol,
    output logic [1:0]        viol_code,
    output logic [ADDR_W-1:0] viol_pc,
    output logic [ADDR_W-1:0] conf_pc_a,
    output logic [ADDR_W-1:0] conf_pc_b
);

    localparam int NREG = 2;

    ev_kind_e kind;
    assign kind = ev_kind_e'(ev_kind);

    hist_t hist [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_hist
        hilo_hist #(.IDX(g)) u_hist (
            .clk      (clk),
            .rst      (rst),
            .ev_valid (ev_valid),
            .ev_kind  (kind),
            .ev_pc    (ev_pc),
            .ev_time  (ev_time),
            .hist     (hist[g])
        );
    end

    viol_e             code_c;
    logic [ADDR_W-1:0] pc_a_c, pc_b_c;

    hilo_rules #(.MIN_GAP(MIN_GAP)) u_rules (
        .ev_valid (ev_valid),
        .ev_kind  (kind),
        .ev_time  (ev_time),
        .relaxed  (relaxed),
        .h_hi     (hist[0]),
        .h_lo     (hist[1]),
        .code     (code_c),
        .pc_a     (pc_a_c),
        .pc_b     (pc_b_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            viol      <= 1'b0;
            viol_code <= '0;
            viol_pc   <= '0;
            conf_pc_a <= '0;
            conf_pc_b <= '0;
        end else begin
            viol      <= (code_c != VC_NONE);
            viol_code <= code_c;
            viol_pc   <= (code_c != VC_NONE) ? ev_pc : '0;
            conf_pc_a <= pc_a_c;
            conf_pc_b <= pc_b_c;
        end
    end

    a_r11_needs_event: assert property (@(posedge clk) disable iff (rst)
        viol |-> $past(ev_valid));

    a_r11_quiet_outputs: assert property (@(posedge clk) disable iff (rst)
        !viol |-> (viol_pc == '0 && conf_pc_a == '0 && conf_pc_b == '0));

    a_r5_relaxed_write: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && relaxed && (ev_kind == 3'd0 || ev_kind == 3'd1)) |=> !viol);

    a_r6_corrupt_from_read: assert property (@(posedge clk) disable iff (rst)
        (viol && viol_code == 2'd3) |-> ($past(ev_kind) == 3'd2 || $past(ev_kind) == 3'd3));

    a_r4_op_code_source: assert property (@(posedge clk) disable iff (rst)
        (viol && viol_code == 2'd2) |-> ($past(ev_kind) == 3'd4 || $past(ev_kind) == 3'd5));

    a_r2_write_code_source: assert property (@(posedge clk) disable iff (rst)
        (viol && viol_code == 2'd1) |-> ($past(ev_kind) == 3'd0 || $past(ev_kind) == 3'd1));

endmodule

// File: tb/test_hilo_hazard_chk.sv
`timescale 1ns/1ps
module test_hilo_hazard_chk;

    localparam logic [2:0] K_WHI = 3'd0, K_WLO = 3'd1, K_RHI = 3'd2,
                           K_RLO = 3'd3, K_MUL = 3'd4, K_DIV = 3'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_kind = '0;
    logic [31:0] ev_pc = '0;
    logic [31:0] ev_time = '0;
    logic        relaxed = 1'b0;
    logic        viol;
    logic [1:0]  viol_code;
    logic [31:0] viol_pc, conf_pc_a, conf_pc_b;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    hilo_hazard_chk i_hilo_hazard_chk (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_pc(ev_pc), .ev_time(ev_time), .relaxed(relaxed),
        .viol(viol), .viol_code(viol_code), .viol_pc(viol_pc),
        .conf_pc_a(conf_pc_a), .conf_pc_b(conf_pc_b)
    );

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ev_valid = 1'b0;
        relaxed = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Present one event; results are sampled 1 ns after the capturing edge
    task automatic ev(input logic [2:0] k, input logic [31:0] pc,
                      input logic [31:0] t, input logic rlx);
        @(negedge clk);
        ev_valid = 1'b1;
        ev_kind  = k;
        ev_pc    = pc;
        ev_time  = t;
        relaxed  = rlx;
        @(posedge clk);
        #1;
        ev_valid = 1'b0;
    endtask

    task automatic chk(input string req, input logic ev_v, input logic [1:0] ec,
                       input logic [31:0] epc, input logic [31:0] ea,
                       input logic [31:0] eb);
        n_chk++;
        if (viol !== ev_v || viol_code !== ec || viol_pc !== epc ||
            conf_pc_a !== ea || conf_pc_b !== eb) begin
            n_fail++;
            $display("FAIL %s: got viol=%0b code=%0d pc=%h a=%h b=%h, expected viol=%0b code=%0d pc=%h a=%h b=%h",
                     req, viol, viol_code, viol_pc, conf_pc_a, conf_pc_b,
                     ev_v, ec, epc, ea, eb);
        end
    endtask

    task automatic chk_quiet(input string req);
        chk(req, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk_quiet("R1 reset outputs");
        ev(K_WHI, 32'h10, 32'd5, 1'b0); chk_quiet("R1 first write");
        ev(K_MUL, 32'h14, 32'd6, 1'b0); chk_quiet("R1 first multiply");
        ev(K_RHI, 32'h18, 32'd7, 1'b0); chk_quiet("R1 first read");
    endtask

    task automatic t_write_gap();
        for (int d = 0; d <= 3; d++) begin
            do_reset();
            ev(K_RHI, 32'h100, 32'd100, 1'b0);
            ev(K_WHI, 32'h104, 32'd100 + 32'(d), 1'b0);
            if (d < 3) chk($sformatf("R2 gap %0d", d), 1'b1, 2'd1, 32'h104, 32'h100, 32'h0);
            else       chk_quiet("R2 gap 3");
        end
        do_reset();
        ev(K_RLO, 32'h120, 32'd50, 1'b0);
        ev(K_WLO, 32'h124, 32'd52, 1'b0);
        chk("R2 LO gap 2", 1'b1, 2'd1, 32'h124, 32'h120, 32'h0);
        // R11: the idle cycle after the pulse is quiet
        @(posedge clk); #1;
        chk_quiet("R11 pulse lasts one cycle");
    endtask

    task automatic t_other_reg();
        do_reset();
        ev(K_RLO, 32'h200, 32'd100, 1'b0);
        ev(K_WHI, 32'h204, 32'd101, 1'b0);
        chk_quiet("R3 other register write");
    endtask

    task automatic t_op_gap();
        do_reset();
        ev(K_RLO, 32'h300, 32'd50, 1'b0);
        ev(K_MUL, 32'h304, 32'd52, 1'b0);
        chk("R4 multiply after LO read", 1'b1, 2'd2, 32'h304, 32'h300, 32'h0);
        do_reset();
        ev(K_RHI, 32'h310, 32'd60, 1'b0);
        ev(K_RLO, 32'h314, 32'd61, 1'b0);
        ev(K_DIV, 32'h318, 32'd62, 1'b0);
        chk("R4 both close, HI first", 1'b1, 2'd2, 32'h318, 32'h310, 32'h0);
        ev(K_DIV, 32'h31c, 32'd64, 1'b0);
        chk_quiet("R4 spacing 3 from LO read");
    endtask

    task automatic t_relaxed();
        do_reset();
        ev(K_RHI, 32'h400, 32'd10, 1'b1);
        ev(K_WHI, 32'h404, 32'd11, 1'b1);
        chk_quiet("R5 relaxed write");
        ev(K_MUL, 32'h408, 32'd12, 1'b1);
        chk_quiet("R5 relaxed multiply");
        ev(K_DIV, 32'h40c, 32'd12, 1'b1);
        chk("R5 relaxed divide still checked", 1'b1, 2'd2, 32'h40c, 32'h400, 32'h0);
    endtask

    task automatic t_corrupt();
        for (int m = 0; m < 2; m++) begin
            do_reset();
            ev(K_MUL, 32'h500, 32'd10, m[0]);
            ev(K_WLO, 32'h504, 32'd20, m[0]);
            ev(K_RHI, 32'h508, 32'd30, m[0]);
            chk($sformatf("R6 corruption mode %0d", m), 1'b1, 2'd3, 32'h508, 32'h500, 32'h504);
        end
        do_reset();
        ev(K_DIV, 32'h520, 32'd10, 1'b0);
        ev(K_WHI, 32'h524, 32'd20, 1'b0);
        ev(K_RLO, 32'h528, 32'd30, 1'b0);
        chk("R6 LO read corrupted", 1'b1, 2'd3, 32'h528, 32'h520, 32'h524);
    endtask

    task automatic t_own_exempt();
        do_reset();
        ev(K_MUL, 32'h600, 32'd10, 1'b0);
        ev(K_RHI, 32'h604, 32'd15, 1'b0);
        ev(K_WLO, 32'h608, 32'd20, 1'b0);
        ev(K_RHI, 32'h60c, 32'd30, 1'b0);
        chk_quiet("R7 own read in window");
        do_reset();
        ev(K_RHI, 32'h610, 32'd10, 1'b0);
        ev(K_MUL, 32'h614, 32'd10, 1'b0);
        ev(K_WLO, 32'h618, 32'd20, 1'b0);
        ev(K_RHI, 32'h61c, 32'd30, 1'b0);
        chk("R7 read at operation time", 1'b1, 2'd3, 32'h61c, 32'h614, 32'h618);
    endtask

    task automatic t_peer_exempt();
        do_reset();
        ev(K_MUL, 32'h700, 32'd10, 1'b0);
        ev(K_RLO, 32'h704, 32'd15, 1'b0);
        ev(K_WLO, 32'h708, 32'd20, 1'b0);
        ev(K_RHI, 32'h70c, 32'd30, 1'b0);
        chk_quiet("R8 peer read in window");
    endtask

    task automatic t_own_write();
        do_reset();
        ev(K_MUL, 32'h800, 32'd10, 1'b0);
        ev(K_WHI, 32'h804, 32'd12, 1'b0);
        ev(K_WLO, 32'h808, 32'd20, 1'b0);
        ev(K_RHI, 32'h80c, 32'd30, 1'b0);
        chk_quiet("R9 own write after operation");
    endtask

    task automatic t_update_on_flag();
        do_reset();
        ev(K_RHI, 32'h900, 32'd100, 1'b0);
        ev(K_WHI, 32'h904, 32'd101, 1'b0);
        chk("R10 first write flagged", 1'b1, 2'd1, 32'h904, 32'h900, 32'h0);
        ev(K_RHI, 32'h908, 32'd102, 1'b0);
        ev(K_WHI, 32'h90c, 32'd103, 1'b0);
        chk("R10 read record replaced", 1'b1, 2'd1, 32'h90c, 32'h908, 32'h0);
        ev(K_MUL, 32'h910, 32'd104, 1'b0);
        chk("R10 multiply flagged", 1'b1, 2'd2, 32'h910, 32'h908, 32'h0);
        ev(K_WLO, 32'h914, 32'd110, 1'b0);
        ev(K_RHI, 32'h918, 32'd120, 1'b0);
        chk("R10 flagged multiply recorded", 1'b1, 2'd3, 32'h918, 32'h910, 32'h914);
    endtask

    task automatic t_ignored();
        do_reset();
        ev(K_RHI, 32'ha00, 32'd100, 1'b0);
        ev(3'd6, 32'ha04, 32'd101, 1'b0);
        chk_quiet("R11 kind 6 ignored");
        ev(3'd7, 32'ha08, 32'd200, 1'b0);
        ev(K_WHI, 32'ha0c, 32'd101, 1'b0);
        chk("R11 kind 7 left history intact", 1'b1, 2'd1, 32'ha0c, 32'ha00, 32'h0);
    endtask

    initial begin
        t_reset();
        t_write_gap();
        t_other_reg();
        t_op_gap();
        t_relaxed();
        t_corrupt();
        t_own_exempt();
        t_peer_exempt();
        t_own_write();
        t_update_on_flag();
        t_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got run still active, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule